// File: doc/BRIEF.md
# PWM Timebase Clock Generator

This block turns a master clock into the two timing enables that pace a bank of PWM generators. The first enable comes from a power-of-two divider: a small counter runs while the block is enabled, and it raises a one-cycle tick once every 2, 4, 8 or 16 master clocks, as the divider select chooses. The second enable comes from a fractional rate generator. On every enabled master clock, a programmable step is added to an accumulator. Whenever the running sum passes a programmable threshold, the block emits a one-cycle pulse and keeps the excess. Because the excess carries over, the long-run pulse rate is step/threshold of the master clock. The threshold therefore sets the shortest spacing between pulses.

Software programs the block through a simple write port that has an address and a data word. A lock bit guards the divider select, the step and the threshold. Software can set the lock at any time. To clear it, software must write two key words on back-to-back cycles, and the very next write must be a lock-clear. The divider select also stays frozen while the block is enabled, so the divided timebase never changes ratio in the middle of a run.

Top module: `pwm_timebase_gen`

## Requirements
- R1: The divider select (address 0, data bits [1:0]) picks the ratio: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16. While enabled with ratio N, `div_tick_o` is combinationally high in exactly one cycle out of N. It goes high first in the N-th enabled cycle.
- R2: A write to the divider select while `enable` is high is ignored. A write made while `enable` is low takes effect on the next run.
- R3: Each enabled clock adds the step (address 1) to the accumulator. When the sum is strictly greater than the threshold (address 2), the threshold is subtracted and `scale_tick_o` is high in the following cycle. For step ≤ threshold, after k enabled clocks the pulse count is ceil(k·step/threshold) − 1, or 0 when k·step is 0.
- R4: When the step is greater than the threshold (this includes a threshold of 0 with a nonzero step), `scale_tick_o` is high on every enabled cycle. A step of 0 gives no pulses.
- R5: While `enable` is low, both ticks are low and both the divider counter and the accumulator return to zero. Re-enabling restarts both phases from zero.
- R6: While `locked_o` is 1, writes to addresses 0, 1 and 2 are ignored.
- R7: Writing address 3 with data bit 0 = 0 clears the lock only when two conditions hold. First, that write must immediately follow, among writes, a write of the second key 16'h5AA5 to address 4. Second, that key write must come on the cycle right after a write of the first key 16'hA55A to address 4. Any other order leaves the lock set.
- R8: After reset the block is unlocked, with ratio 2, step 0 and threshold 0, and both ticks low. Writing address 3 with data bit 0 = 1 sets the lock at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider and the accumulator |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 3 | Register select: 0 divider, 1 step, 2 threshold, 3 lock, 4 key |
| wr_data | input | 16 | Write data |
| div_tick_o | output | 1 | One-cycle divided-clock enable |
| scale_tick_o | output | 1 | One-cycle scaled-clock pulse |
| locked_o | output | 1 | Current lock state |

## Verification
The bench sweeps all four divider ratios and checks every cycle. If the terminal count were off by one, the tick period would come out one cycle wrong. If a run did not restart from zero, the first tick would appear early after re-enable. The accumulator runs with several step and threshold pairs, including step equal to the threshold, step above it and a zero step. Each cycle is compared with the closed-form pulse count. A `>=` in place of `>`, or a lost remainder, moves pulses, and a missing clip wraps the accumulator. The lock is tested with wrong key orders, with a gap between the keys, and with an unrelated write between the keys and the clear. A sloppy key check would drop the lock in one of these cases. The bench also changes the divider select mid-run, which a design without the run freeze would obey.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_DIVSEL = 3'd0,
      RA_STEP   = 3'd1,
      RA_MINPER = 3'd2,
      RA_LOCK   = 3'd3,
      RA_KEY    = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/ptb_cfg_regs.sv
`timescale 1ns/1ps
module ptb_cfg_regs
   import ptb_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SEL_W  = 2,
   parameter logic [DATA_W-1:0] KEY_A = 16'hA55A,
   parameter logic [DATA_W-1:0] KEY_B = 16'h5AA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEL_W-1:0]  div_sel,
   output logic [DATA_W-1:0] step,
   output logic [DATA_W-1:0] minper,
   output logic              locked
);
   logic [SEL_W-1:0]  div_sel_q;
   logic [DATA_W-1:0] step_q, minper_q;
   logic              locked_q, key_a_seen_q, armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_sel_q    <= '0;
         step_q       <= '0;
         minper_q     <= '0;
         locked_q     <= 1'b0;
         key_a_seen_q <= 1'b0;
         armed_q      <= 1'b0;
      end else begin
         key_a_seen_q <= wr_en && (wr_addr == RA_KEY) && (wr_data == KEY_A);
         if (wr_en) begin
            armed_q <= (wr_addr == RA_KEY) && (wr_data == KEY_B) && key_a_seen_q;
            case (wr_addr)
               RA_DIVSEL: if (!locked_q && !en) div_sel_q <= wr_data[SEL_W-1:0];
               RA_STEP:   if (!locked_q) step_q <= wr_data;
               RA_MINPER: if (!locked_q) minper_q <= wr_data;
               RA_LOCK: begin
                  if (wr_data[0])   locked_q <= 1'b1;
                  else if (armed_q) locked_q <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   assign div_sel = div_sel_q;
   assign step    = step_q;
   assign minper  = minper_q;
   assign locked  = locked_q;

   // R2: ratio frozen during a run
   p_divsel_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(div_sel_q));
   // R6: protected settings hold while locked
   p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> ($stable(step_q) && $stable(minper_q) && $stable(div_sel_q)));
   // R7: lock only drops after an armed key pair
   p_unlock_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> $past(armed_q));
endmodule

// File: rtl/ptb_pow2_div.sv
`timescale 1ns/1ps
module ptb_pow2_div #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned NUM_RATIO = 2 ** SEL_W;
   localparam int unsigned CNT_W     = NUM_RATIO;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("ptb_pow2_div: SEL_W must lie in 1..4");
   end

   logic [CNT_W-1:0] term_tbl [NUM_RATIO];
   for (genvar i = 0; i < NUM_RATIO; i++) begin : g_term
      localparam logic [CNT_W:0] TV = ({{CNT_W{1'b0}}, 1'b1} << (i + 1)) - 1'b1;
      assign term_tbl[i] = TV[CNT_W-1:0];
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   assign term = term_tbl[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!en)          cnt_q <= '0;
      else if (cnt_q >= term) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = en && (cnt_q == term);

   // R1: ratio is at least two, so ticks never repeat back to back
   p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en) |=> !(tick && $past(sel) == sel && en && $past(en)));
   // R5: counter parks at zero while idle
   p_cnt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));
endmodule

// File: rtl/ptb_frac_scaler.sv
`timescale 1ns/1ps
module ptb_frac_scaler #(
   parameter int unsigned DATA_W    = 16,
   parameter bit          CARRY_REM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DATA_W-1:0] step,
   input  logic [DATA_W-1:0] minper,
   output logic              tick
);
   localparam int unsigned ACC_W = DATA_W + 1;

   logic [ACC_W-1:0] acc_q, sum, diff, rem, thr;
   logic             over, tick_q;

   assign thr  = {1'b0, minper};
   assign sum  = acc_q + {1'b0, step};
   assign over = sum > thr;
   assign diff = sum - thr;

   if (CARRY_REM) begin : g_carry
      assign rem = (diff > thr) ? thr : diff;
   end else begin : g_drop
      assign rem = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (!en) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= over;
         acc_q  <= over ? rem : sum;
      end
   end

   assign tick = tick_q;

   // R3: after a pulse the kept remainder never exceeds the threshold
   p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> (acc_q <= {1'b0, $past(minper)}));
   // R5: idle clears pulse and accumulator
   p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!tick_q && acc_q == '0));
endmodule

// File: rtl/pwm_timebase_gen.sv
`timescale 1ns/1ps
module pwm_timebase_gen
   import ptb_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SEL_W     = 2,
   parameter logic [DATA_W-1:0] KEY_A = 16'hA55A,
   parameter logic [DATA_W-1:0] KEY_B = 16'h5AA5,
   parameter bit          CARRY_REM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              div_tick_o,
   output logic              scale_tick_o,
   output logic              locked_o
);
   if (DATA_W < 4 || DATA_W > 32 || SEL_W >= DATA_W) begin : g_bad_w
      $error("pwm_timebase_gen: DATA_W must be 4..32 and wider than SEL_W");
   end

   logic [SEL_W-1:0]  div_sel;
   logic [DATA_W-1:0] step, minper;

   ptb_cfg_regs #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (enable),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .div_sel (div_sel),
      .step    (step),
      .minper  (minper),
      .locked  (locked_o)
   );

   ptb_pow2_div #(
      .SEL_W (SEL_W)
   ) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .sel   (div_sel),
      .tick  (div_tick_o)
   );

   ptb_frac_scaler #(
      .DATA_W    (DATA_W),
      .CARRY_REM (CARRY_REM)
   ) i_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .step   (step),
      .minper (minper),
      .tick   (scale_tick_o)
   );

   // R8: nothing ticks while idle
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !scale_tick_o);
endmodule

// File: tb/test_pwm_timebase_gen.sv
`timescale 1ns/1ps
module test_pwm_timebase_gen;
   localparam logic [15:0] KA = 16'hA55A;
   localparam logic [15:0] KB = 16'h5AA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        div_tick_o, scale_tick_o, locked_o;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   pwm_timebase_gen i_pwm_timebase_gen (
      .clk, .rst_n, .enable, .wr_en, .wr_addr, .wr_data,
      .div_tick_o, .scale_tick_o, .locked_o
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: got %0b expected %0b", req, $time, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic longint pcount(input longint t, input longint m);
      return (t == 0) ? 0 : ((t + m - 1) / m - 1);
   endfunction

   function automatic logic exp_scale(input int k, input longint s, input longint m);
      if (s == 0) return 1'b0;
      if (s > m)  return 1'b1;
      return pcount(k * s, m) != pcount((k - 1) * s, m);
   endfunction

   // enable from idle, check both outputs for k cycles, then go idle
   task automatic run_cfg(input int n, input longint s, input longint m, input int k,
                          input string tdiv, input string tscl);
      enable = 1'b1;
      for (int i = 1; i <= k; i++) begin
         @(negedge clk);
         chk(tdiv, div_tick_o, (i % n) == (n - 1));
         chk(tscl, scale_tick_o, exp_scale(i, s, m));
      end
      enable = 1'b0;
      @(negedge clk);
      chk("R5 idle div", div_tick_o, 1'b0);
      chk("R5 idle scale", scale_tick_o, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 reset div", div_tick_o, 1'b0);
      chk("R8 reset scale", scale_tick_o, 1'b0);
      chk("R8 reset lock", locked_o, 1'b0);
      run_cfg(2, 0, 0, 12, "R8 default ratio", "R8 default step");

      // R1 sweep of ratios, R5 restart after partial run
      for (int sel = 0; sel < 4; sel++) begin
         wr(3'd0, 16'(sel));
         run_cfg(2 << sel, 0, 0, 40, "R1 ratio", "R4 zero step");
         run_cfg(2 << sel, 0, 0, 20, "R5 restart", "R4 zero step");
      end

      // R3 carry behaviour, R4 saturation cases
      wr(3'd0, 16'd0);
      wr(3'd1, 16'd3);   wr(3'd2, 16'd10);  run_cfg(2, 3, 10, 60, "R1", "R3 3/10");
      wr(3'd1, 16'd7);   wr(3'd2, 16'd16);  run_cfg(2, 7, 16, 60, "R1", "R3 7/16");
      wr(3'd1, 16'd1);   wr(3'd2, 16'd5);   run_cfg(2, 1, 5, 30, "R1", "R3 1/5");
      wr(3'd1, 16'd5);   wr(3'd2, 16'd5);   run_cfg(2, 5, 5, 20, "R1", "R3 equal");
      wr(3'd1, 16'd100); wr(3'd2, 16'd250); run_cfg(2, 100, 250, 40, "R1", "R3 100/250");
      wr(3'd1, 16'hFFFF); wr(3'd2, 16'hFFFE); run_cfg(2, 65535, 65534, 20, "R1", "R3 wide");
      wr(3'd1, 16'd20);  wr(3'd2, 16'd7);   run_cfg(2, 20, 7, 20, "R1", "R4 step above");
      wr(3'd1, 16'd4);   wr(3'd2, 16'd0);   run_cfg(2, 4, 0, 20, "R1", "R4 zero thr");

      // R2: divider select frozen while running
      wr(3'd0, 16'd0);
      wr(3'd1, 16'd0);
      enable = 1'b1;
      for (int i = 1; i <= 30; i++) begin
         if (i == 5) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd3; end
         else wr_en = 1'b0;
         @(negedge clk);
         chk("R2 frozen ratio", div_tick_o, (i % 2) == 1);
      end
      wr_en = 1'b0;
      enable = 1'b0;
      @(negedge clk);
      wr(3'd0, 16'd3);
      run_cfg(16, 0, 0, 40, "R2 idle write applies", "R4");

      // R6 lock protection
      wr(3'd0, 16'd1); wr(3'd1, 16'd1); wr(3'd2, 16'd3);
      wr(3'd3, 16'd1);
      chk("R8 lock set", locked_o, 1'b1);
      wr(3'd0, 16'd0); wr(3'd1, 16'd9); wr(3'd2, 16'd2);
      run_cfg(4, 1, 3, 24, "R6 ratio held", "R6 scale held");

      // R7 unlock sequences
      wr(3'd4, KB); wr(3'd4, KA); wr(3'd3, 16'd0);
      chk("R7 reversed keys", locked_o, 1'b1);
      wr(3'd4, KA); @(negedge clk); wr(3'd4, KB); wr(3'd3, 16'd0);
      chk("R7 gap between keys", locked_o, 1'b1);
      wr(3'd4, KA); wr(3'd4, KB); wr(3'd1, 16'd5); wr(3'd3, 16'd0);
      chk("R7 write between", locked_o, 1'b1);
      wr(3'd4, KA); wr(3'd4, 16'h1234); wr(3'd3, 16'd0);
      chk("R7 wrong key", locked_o, 1'b1);
      run_cfg(4, 1, 3, 12, "R6 still held", "R6 still held");
      wr(3'd4, KA); wr(3'd4, KB); wr(3'd3, 16'd0);
      chk("R7 good unlock", locked_o, 1'b0);

      // R6 complement: writes land once unlocked
      wr(3'd0, 16'd2); wr(3'd1, 16'd2); wr(3'd2, 16'd9);
      run_cfg(8, 2, 9, 40, "R6 unlocked ratio", "R6 unlocked scale");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule